// File: doc/BRIEF.md
# DTMF Guard-Time Steering Controller

This block sits behind a DTMF tone detector. It turns the detector's raw "tone present" indication into a clean, debounced steering signal. A tone is accepted only after the raw indication has stayed high long enough. At that point the 4-bit digit code is captured into a holding register and a one-cycle data-valid strobe is issued.

Once a tone is held, it is released only after the raw indication has stayed low long enough, and a one-cycle absence strobe marks the release. Two independent tick counts set the two guard intervals. Short dropouts inside a held tone are therefore bridged, and short bursts never register.

An enable input models receiver power-down. While it is low, the steering output and both strobes stay inactive and the guard timer is cleared. The last captured code is kept.

Top module: `tone_steer_top`

## Requirements
- R1: While reset is asserted and right after it, `steerOut`, `dataValid` and `absenceSeen` are 0 and `codeOut` is 0.
- R2: With no tone held, a run of `presenceTicks`+1 consecutive clock edges that sample `toneRaw` high registers the tone on the last edge of that run. `codeOut` then takes the `toneCode` value sampled on that edge.
- R3: A high run of `toneRaw` shorter than `presenceTicks`+1 edges, followed by a low sample, registers nothing and raises no strobe. The presence count restarts from zero.
- R4: `steerOut` rises in the same cycle that `dataValid` is 1. `dataValid` is high for exactly one clock per registered tone.
- R5: With a tone held, a run of `absenceTicks`+1 consecutive edges that sample `toneRaw` low releases the tone on the last edge of that run. `steerOut` falls and `absenceSeen` is 1 for exactly that one clock.
- R6: While a tone is held, a low run of at most `absenceTicks` edges followed by a high sample keeps `steerOut` high. It gives no second `dataValid`, no `absenceSeen`, and leaves `codeOut` unchanged even when `toneCode` changes.
- R7: The presence and absence intervals act independently, each set only by its own 16-bit count.
- R8: A count of 0 means immediate action. The first high sample registers the tone, and the first low sample of a held tone releases it.
- R9: While `enable` is 0, `steerOut`, `dataValid` and `absenceSeen` are 0 and any held tone is dropped without an absence strobe. The guard count is cleared, so acceptance after re-enable needs a full new presence run. `codeOut` keeps its value.
- R10: `dataValid` and `absenceSeen` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Receiver enable; 0 = powered down |
| toneRaw | input | 1 | Raw tone-present indication from the detector |
| toneCode | input | 4 | Digit code from the detector |
| presenceTicks | input | 16 | Presence guard interval in clock ticks |
| absenceTicks | input | 16 | Absence guard interval in clock ticks |
| steerOut | output | 1 | Debounced steering: a tone is held |
| codeOut | output | 4 | Captured digit code |
| dataValid | output | 1 | One-cycle strobe: a new code was captured |
| absenceSeen | output | 1 | One-cycle strobe: a held tone was released |

## Verification
The critical same-cycle coincidence is a held tone's absence interval running out on the very edge where `toneRaw` returns high. There, the restart must win and no release may be declared.

The bench provokes this by sweeping both guard counts over 0 to 3. For each pair it drives a dropout of exactly `absenceTicks` low samples followed by a high sample. It then drives a gap of `absenceTicks`+1 low samples. It judges that the first leaves steering high with the code and strobe counts unchanged, and that the second yields one absence strobe at the computed index.

The second overlap, power-down arriving mid-presence or mid-hold, is judged by the strobe counts and the restart index after re-enable.

// File: rtl/tone_steer_pkg.sv
package tone_steer_pkg;

  // strobes issued by the control FSM to the datapath each cycle
  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic loadCode;
    logic pulseValid;
    logic pulseAbsent;
  } steerCmd_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HELD = 1'b1
  } steerState_e;

endpackage

// File: rtl/tone_steer_ctrl.sv
module tone_steer_ctrl
  import tone_steer_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      toneRaw,
  input  logic      presDone,
  input  logic      absDone,
  output logic      held,
  output steerCmd_t cmd
);

  steerState_e state, stateNext;

  always_comb begin
    cmd       = '0;
    stateNext = state;
    if (!enable) begin
      cmd.cntClear = 1'b1;
      stateNext    = ST_IDLE;
    end else if (state == ST_IDLE) begin
      if (toneRaw) begin
        if (presDone) begin
          cmd.loadCode   = 1'b1;
          cmd.pulseValid = 1'b1;
          cmd.cntClear   = 1'b1;
          stateNext      = ST_HELD;
        end else begin
          cmd.cntInc = 1'b1;
        end
      end else begin
        cmd.cntClear = 1'b1;
      end
    end else begin
      if (!toneRaw) begin
        if (absDone) begin
          cmd.pulseAbsent = 1'b1;
          cmd.cntClear    = 1'b1;
          stateNext       = ST_IDLE;
        end else begin
          cmd.cntInc = 1'b1;
        end
      end else begin
        cmd.cntClear = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  assign held = (state == ST_HELD);

  // R2
  hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> $past(toneRaw) && $past(enable));

  // R5
  hold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held) && $past(enable) |-> !$past(toneRaw));

  // R9
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> !held);

endmodule

// File: rtl/tone_steer_dp.sv
module tone_steer_dp
  import tone_steer_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  steerCmd_t         cmd,
  input  logic              held,
  input  logic [CODE_W-1:0] toneCode,
  input  logic [CNT_W-1:0]  presenceTicks,
  input  logic [CNT_W-1:0]  absenceTicks,
  output logic              presDone,
  output logic              absDone,
  output logic [CODE_W-1:0] codeOut,
  output logic              dataValid,
  output logic              absenceSeen
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] guardCnt;

  // the counter only advances while below the active threshold, so it stays in range
  always_ff @(posedge clk) begin
    if (!rst_n)            guardCnt <= '0;
    else if (cmd.cntClear) guardCnt <= '0;
    else if (cmd.cntInc)   guardCnt <= guardCnt + CNT_ONE;
  end

  assign presDone = (guardCnt >= presenceTicks);
  assign absDone  = (guardCnt >= absenceTicks);

  always_ff @(posedge clk) begin
    if (!rst_n)            codeOut <= '0;
    else if (cmd.loadCode) codeOut <= toneCode;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dataValid   <= 1'b0;
      absenceSeen <= 1'b0;
    end else begin
      dataValid   <= cmd.pulseValid;
      absenceSeen <= cmd.pulseAbsent;
    end
  end

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dataValid |=> !dataValid);

  // R5
  absent_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    absenceSeen |=> !absenceSeen);

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dataValid && absenceSeen));

  // R4
  valid_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dataValid |-> held);

  // R6
  code_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held && $past(held) |-> $stable(codeOut));

endmodule

// File: rtl/tone_steer_top.sv
module tone_steer_top
  import tone_steer_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              toneRaw,
  input  logic [CODE_W-1:0] toneCode,
  input  logic [CNT_W-1:0]  presenceTicks,
  input  logic [CNT_W-1:0]  absenceTicks,
  output logic              steerOut,
  output logic [CODE_W-1:0] codeOut,
  output logic              dataValid,
  output logic              absenceSeen
);

  steerCmd_t cmd;
  logic      held;
  logic      presDone;
  logic      absDone;

  tone_steer_ctrl ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .toneRaw  (toneRaw),
    .presDone (presDone),
    .absDone  (absDone),
    .held     (held),
    .cmd      (cmd)
  );

  tone_steer_dp #(.CODE_W(CODE_W), .CNT_W(CNT_W)) dp_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd           (cmd),
    .held          (held),
    .toneCode      (toneCode),
    .presenceTicks (presenceTicks),
    .absenceTicks  (absenceTicks),
    .presDone      (presDone),
    .absDone       (absDone),
    .codeOut       (codeOut),
    .dataValid     (dataValid),
    .absenceSeen   (absenceSeen)
  );

  assign steerOut = held;

endmodule

// File: tb/tone_steer_top_tb_top.sv
`timescale 1ns/1ps
module tone_steer_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b1;
  logic        toneRaw = 1'b0;
  logic [3:0]  toneCode = '0;
  logic [15:0] presenceTicks = '0;
  logic [15:0] absenceTicks = '0;
  logic        steerOut;
  logic [3:0]  codeOut;
  logic        dataValid;
  logic        absenceSeen;

  int nChecks = 0;
  int nFail   = 0;
  int sDv, sAbs, bothCnt;

  always #2 clk = ~clk;

  tone_steer_top dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .toneRaw(toneRaw),
    .toneCode(toneCode), .presenceTicks(presenceTicks),
    .absenceTicks(absenceTicks), .steerOut(steerOut), .codeOut(codeOut),
    .dataValid(dataValid), .absenceSeen(absenceSeen)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive inputs, pass one rising edge, then sample 1 ns later
  task automatic tick(input logic raw, input int code);
    toneRaw  = raw;
    toneCode = 4'(code);
    @(posedge clk);
    #1;
    sDv  = int'(dataValid);
    sAbs = int'(absenceSeen);
    if (dataValid && absenceSeen) bothCnt++;
  endtask

  initial begin
    #800000;
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    int dv, ab, dvIdx, absIdx;
    bothCnt = 0;
    repeat (3) @(posedge clk);
    #1;
    check(!steerOut && !dataValid && !absenceSeen && codeOut == 0, "R1",
          int'({steerOut, dataValid, absenceSeen, codeOut}), 0);
    rst_n = 1'b1;
    tick(0, 0);
    check(!steerOut && !dataValid && !absenceSeen && codeOut == 0, "R1",
          int'({steerOut, dataValid, absenceSeen, codeOut}), 0);

    for (int p = 0; p < 4; p++) begin
      for (int a = 0; a < 4; a++) begin
        int c;
        c = p * 4 + a;
        presenceTicks = 16'(p);
        absenceTicks  = 16'(a);
        tick(0, c);
        tick(0, c);
        // R3: burst one tick too short
        dv = 0;
        for (int i = 0; i < p; i++) begin tick(1, c); dv += sDv; end
        for (int i = 0; i < 2; i++) begin tick(0, c); dv += sDv; end
        check(dv == 0 && !steerOut, "R3", dv, 0);
        // R2: acceptance exactly on edge index p
        dvIdx = -1;
        for (int i = 0; i <= p; i++) begin
          tick(1, c);
          if (sDv != 0 && dvIdx < 0) dvIdx = i;
        end
        check(dvIdx == p, "R2", dvIdx, p);
        check(int'(codeOut) == c, "R2", int'(codeOut), c);
        check(steerOut == 1'b1, "R4", int'(steerOut), 1);
        if (p == 0) check(dvIdx == 0, "R8", dvIdx, 0);
        // R4 one pulse only, R6 code held while toneCode changes
        dv = 0;
        for (int i = 0; i < 3; i++) begin tick(1, c ^ 5); dv += sDv; end
        check(dv == 0 && int'(codeOut) == c, "R4", dv, 0);
        // R6: dropout of exactly a low samples then tone returns
        if (a > 0) begin
          dv = 0; ab = 0;
          for (int i = 0; i < a; i++) begin tick(0, c ^ 3); ab += sAbs; dv += sDv; end
          for (int i = 0; i < 2; i++) begin tick(1, c ^ 3); ab += sAbs; dv += sDv; end
          check(ab == 0 && dv == 0 && steerOut && int'(codeOut) == c, "R6",
                ab + dv, 0);
        end
        // R5: release on low edge index a
        absIdx = -1;
        for (int i = 0; i <= a; i++) begin
          tick(0, c);
          if (sAbs != 0 && absIdx < 0) absIdx = i;
        end
        check(absIdx == a, "R5", absIdx, a);
        check(!steerOut, "R5", int'(steerOut), 0);
        check(dvIdx - absIdx == p - a, "R7", dvIdx - absIdx, p - a);
        if (a == 0) check(absIdx == 0, "R8", absIdx, 0);
        ab = 0;
        for (int i = 0; i < 2; i++) begin tick(0, c); ab += sAbs; end
        check(ab == 0, "R5", ab, 0);
      end
    end

    // R9: power-down while held and while counting presence
    presenceTicks = 16'd2;
    absenceTicks  = 16'd1;
    for (int i = 0; i < 3; i++) tick(1, 9);
    check(steerOut && codeOut == 4'd9, "R9", int'(steerOut), 1);
    enable = 1'b0;
    dv = 0; ab = 0;
    for (int i = 0; i < 3; i++) begin tick(1, 4); dv += sDv; ab += sAbs; end
    check(dv == 0 && ab == 0 && !steerOut, "R9", dv + ab + int'(steerOut), 0);
    check(codeOut == 4'd9, "R9", int'(codeOut), 9);
    enable = 1'b1;
    tick(1, 4);
    tick(1, 4);
    enable = 1'b0;
    tick(1, 4);
    enable = 1'b1;
    dvIdx = -1;
    for (int i = 0; i < 4; i++) begin
      tick(1, 4);
      if (sDv != 0 && dvIdx < 0) dvIdx = i;
    end
    check(dvIdx == 2, "R9", dvIdx, 2);
    check(codeOut == 4'd4, "R9", int'(codeOut), 4);

    check(bothCnt == 0, "R10", bothCnt, 0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule